// File: doc/BRIEF.md
# Write-Only Slow Peripheral Bridge

This block lets a host processor, running its bus on a fast two-phase clock, store values into the registers of a slower peripheral that must keep its own low-rate phase-2 clock. The host cannot be held off during a write. The bridge therefore takes each qualifying store in a single host cycle. It keeps the register index and the data in holding registers. It then replays the store toward the peripheral as one select pulse, timed on the peripheral's clock.

A store qualifies when the external page decode is active, the host R/W line shows a write, and the upper address bits match a parameterised 32-byte window. The index is sampled at the end of host phase 1, where the address is settled. The data is sampled at the falling edge of host phase 2, because write data on this bus becomes valid only well into phase 2. A request toggle crosses into the peripheral domain through a two-stage synchroniser. There, a divider generates the free-running peripheral clock, and the select pulse is placed on that clock's falling edges.

While a store is in flight, the bridge shows busy to the host side. A further store that arrives in that time is discarded, and a sticky overrun flag records it. Software must therefore space its stores.

Top module: `slowbr_top`

## Requirements
- R1: A host write cycle (h_iosel=1, h_rw=0) whose address lies in the window BASE..BASE+31 gives exactly one low pulse on p_cs_n. During that pulse, p_addr equals h_addr[4:0] of that cycle.
- R2: The data presented on p_data is the value h_data held at the falling edge of h_phi2 in the accepted cycle. A value present just after the rising edge is not used.
- R3: Read cycles (h_rw=1) and cycles with h_iosel=0 do not set h_busy and give no p_cs_n pulse.
- R4: p_cs_n stays low for exactly DIV ref_clk cycles. It falls and rises on the same ref_clk edges at which p_phi2 falls.
- R5: p_addr and p_data do not change while p_cs_n is low.
- R6: p_rw is driven low (write) at all times.
- R7: p_phi2 runs continuously with a period of DIV ref_clk cycles, high for DIV/2 of them, whether or not a store is pending.
- R8: h_busy rises at the h_phi2 rising edge that accepts a write and stays high until the matching pulse has ended. A qualifying write seen while busy is dropped with no pulse and sets h_overrun, which stays set until reset.
- R9: While rst_n is low, p_cs_n is 1 and h_busy and h_overrun are 0.
- R10: Addresses BASE+31 and BASE are accepted. BASE+32 and BASE-1 are ignored: no busy and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the peripheral domain, divided by DIV to form p_phi2 |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| h_phi2 | input | 1 | Host phase-2 clock; low is phase 1 |
| h_addr | input | AW | Host address bus |
| h_data | input | DW | Host write data bus |
| h_rw | input | 1 | Host read/write, 1 = read, 0 = write |
| h_iosel | input | 1 | External page decode, active high |
| h_busy | output | 1 | A captured store has not yet finished its select pulse |
| h_overrun | output | 1 | Sticky: a store was dropped because the bridge was busy |
| p_phi2 | output | 1 | Free-running peripheral phase-2 clock |
| p_addr | output | 5 | Register index held for the peripheral |
| p_data | output | DW | Write data held for the peripheral |
| p_cs_n | output | 1 | Active-low peripheral select |
| p_rw | output | 1 | Peripheral read/write, held at 0 (write) |

## Verification
h_busy and h_overrun are due at the h_phi2 rising edge that sees the cycle. The bench samples them 1 ns after that edge. The select pulse starts on the first p_phi2 falling edge that comes at least three ref_clk edges after the host's data-capture edge. Because the two clocks are unrelated, that edge cannot be named in advance. The monitor therefore waits for the fall of p_cs_n, compares the held index and data with the oldest queued expectation, and then counts ref_clk edges until the rise, expecting exactly DIV. Misses and dropped stores push nothing onto the queue. Any pulse that finds the queue empty is reported, and the queue must be empty once everything has drained.

// File: rtl/slowbr_pkg.sv
package slowbr_pkg;
  localparam int unsigned IDX_W = 5;
  typedef logic [IDX_W-1:0] reg_idx_t;
endpackage

// File: rtl/slowbr_rst_sync.sv
module slowbr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/slowbr_host_cap.sv
module slowbr_host_cap
  import slowbr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] BASE = 16'hD200
) (
  input  logic          phi2,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          rw,
  input  logic          iosel,
  input  logic          ack_tgl,
  output reg_idx_t      idx_hold,
  output logic [DW-1:0] data_hold,
  output logic          req_tgl,
  output logic          busy,
  output logic          overrun
);
  localparam int unsigned TAG_W = AW - IDX_W;

  logic [1:0]    ack_sync_q;
  reg_idx_t      idx_q, idx_d;
  logic          take_q, take_d;
  logic          busy_q, busy_d;
  logic          ovr_q, ovr_d;
  logic [DW-1:0] data_q;
  logic          req_q;
  logic          hit, accept;

  assign hit    = iosel & ~rw & (addr[AW-1:IDX_W] == BASE[AW-1:IDX_W]);
  assign accept = hit & ~busy_q;

  always_comb begin
    idx_d  = accept ? addr[IDX_W-1:0] : idx_q;
    take_d = accept;
    busy_d = accept | (busy_q & (ack_sync_q[1] != req_q));
    ovr_d  = ovr_q | (hit & busy_q);
  end

  // end of phase 1: index and acceptance
  always_ff @(posedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      ack_sync_q <= '0;
      idx_q      <= '0;
      take_q     <= 1'b0;
      busy_q     <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      ack_sync_q <= {ack_sync_q[0], ack_tgl};
      idx_q      <= idx_d;
      take_q     <= take_d;
      busy_q     <= busy_d;
      ovr_q      <= ovr_d;
    end
  end

  // end of phase 2: data, then request toggle
  always_ff @(negedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      req_q  <= 1'b0;
    end else if (take_q) begin
      data_q <= data;
      req_q  <= ~req_q;
    end
  end

  assign idx_hold  = idx_q;
  assign data_hold = data_q;
  assign req_tgl   = req_q;
  assign busy      = busy_q;
  assign overrun   = ovr_q;

  // R8
  idle_handshake_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    !busy_q |-> (ack_sync_q[1] == req_q));

  // R8
  overrun_sticky_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  logic unused_tag;
  assign unused_tag = ^TAG_W;
endmodule

// File: rtl/slowbr_slow_sel.sv
module slowbr_slow_sel #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic phi2,
  output logic cs_n,
  output logic ack_tgl
);
  localparam int unsigned CW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phi2_q, phi2_d;
  logic [2:0]    sync_q;
  logic          pend_q, pend_d;
  logic          cs_n_q, cs_n_d;
  logic          ack_q, ack_d;
  logic          wrap, new_req;

  assign wrap    = (cnt_q == CW'(DIV - 1));
  assign new_req = sync_q[1] ^ sync_q[2];

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    phi2_d = (cnt_d >= CW'(HALF));
    pend_d = new_req | (pend_q & ~(wrap & cs_n_q));
    cs_n_d = cs_n_q;
    ack_d  = ack_q;
    if (wrap) begin
      if (!cs_n_q) begin
        cs_n_d = 1'b1;
        ack_d  = sync_q[2];
      end else if (pend_q) begin
        cs_n_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      phi2_q <= 1'b0;
      sync_q <= '0;
      pend_q <= 1'b0;
      cs_n_q <= 1'b1;
      ack_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      phi2_q <= phi2_d;
      sync_q <= {sync_q[1:0], req_tgl};
      pend_q <= pend_d;
      cs_n_q <= cs_n_d;
      ack_q  <= ack_d;
    end
  end

  assign phi2    = phi2_q;
  assign cs_n    = cs_n_q;
  assign ack_tgl = ack_q;

  // R4
  cs_fall_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> $fell(phi2_q));

  // R4
  cs_rise_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> $fell(phi2_q));
endmodule

// File: rtl/slowbr_top.sv
module slowbr_top
  import slowbr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] BASE = 16'hD200,
  parameter int unsigned DIV = 8
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          h_phi2,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_data,
  input  logic          h_rw,
  input  logic          h_iosel,
  output logic          h_busy,
  output logic          h_overrun,
  output logic          p_phi2,
  output logic [4:0]    p_addr,
  output logic [DW-1:0] p_data,
  output logic          p_cs_n,
  output logic          p_rw
);
  logic     host_rst_n, slow_rst_n;
  logic     req_tgl, ack_tgl;
  reg_idx_t idx_hold;

  slowbr_rst_sync u_host_rst (.clk(h_phi2),  .arst_n(rst_n), .srst_n(host_rst_n));
  slowbr_rst_sync u_slow_rst (.clk(ref_clk), .arst_n(rst_n), .srst_n(slow_rst_n));

  slowbr_host_cap #(.AW(AW), .DW(DW), .BASE(BASE)) u_host (
    .phi2(h_phi2), .rst_n(host_rst_n), .addr(h_addr), .data(h_data),
    .rw(h_rw), .iosel(h_iosel), .ack_tgl(ack_tgl), .idx_hold(idx_hold),
    .data_hold(p_data), .req_tgl(req_tgl), .busy(h_busy), .overrun(h_overrun)
  );

  slowbr_slow_sel #(.DIV(DIV)) u_slow (
    .clk(ref_clk), .rst_n(slow_rst_n), .req_tgl(req_tgl),
    .phi2(p_phi2), .cs_n(p_cs_n), .ack_tgl(ack_tgl)
  );

  assign p_addr = idx_hold;
  assign p_rw   = 1'b0;

  // R5
  hold_stable_chk: assert property (@(posedge ref_clk) disable iff (!slow_rst_n)
    !p_cs_n |-> ($stable(p_addr) && $stable(p_data)));
endmodule

// File: tb/slowbr_top_tb.sv
`timescale 1ns/100ps
module slowbr_top_tb;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
  localparam logic [15:0] BASE = 16'hD200;
  localparam int unsigned DIV = 8;

  logic ref_clk = 1'b0;
  logic h_phi2 = 1'b0;
  logic rst_n;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic h_rw, h_iosel;
  logic h_busy, h_overrun, p_phi2, p_cs_n, p_rw;
  logic [4:0] p_addr;
  logic [DW-1:0] p_data;

  int total = 0;
  int bad = 0;
  logic [12:0] exp_q[$];

  always #2 ref_clk = ~ref_clk;
  initial begin
    #1.3;
    forever #10 h_phi2 = ~h_phi2;
  end

  slowbr_top #(.AW(AW), .DW(DW), .BASE(BASE), .DIV(DIV)) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .h_phi2(h_phi2), .h_addr(h_addr),
    .h_data(h_data), .h_rw(h_rw), .h_iosel(h_iosel), .h_busy(h_busy),
    .h_overrun(h_overrun), .p_phi2(p_phi2), .p_addr(p_addr), .p_data(p_data),
    .p_cs_n(p_cs_n), .p_rw(p_rw)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: one host bus cycle
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                           input logic rw, input logic sel, input bit accept);
    @(negedge h_phi2);
    #2 h_addr = a; h_rw = rw; h_iosel = sel; h_data = 8'h00;
    @(posedge h_phi2);
    #1;
    if (accept) begin
      exp_q.push_back({a[4:0], d});
      chk(h_busy == 1'b1, "R8 busy after accept", h_busy, 1);
    end
    h_data = ~d;          // R2: early value must not be used
    #5 h_data = d;
    @(negedge h_phi2);
    #1 h_rw = 1'b1; h_iosel = 1'b0; h_data = ~d;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && h_busy; i++) @(negedge h_phi2);
    chk(h_busy == 1'b0, "R8 busy clears", h_busy, 0);
  endtask

  // monitor: pop and compare at each select pulse
  initial begin
    logic [12:0] item;
    int n;
    forever begin
      @(negedge p_cs_n);
      #1;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 R8 R10 unexpected pulse", {p_addr, p_data}, 0);
      end else begin
        item = exp_q.pop_front();
        chk({p_addr, p_data} == item, "R1 R2 index/data", {p_addr, p_data}, item);
      end
      chk(p_phi2 == 1'b0, "R4 fall aligned", p_phi2, 0);
      chk(p_rw == 1'b0, "R6 rw at write", p_rw, 0);
      item = {p_addr, p_data};
      n = 0;
      while (p_cs_n == 1'b0 && n < 4 * DIV) begin
        @(posedge ref_clk);
        #1 n++;
        if ({p_addr, p_data} != item)
          chk(1'b0, "R5 hold changed", {p_addr, p_data}, item);
      end
      chk(n == DIV, "R4 width", n, DIV);
      chk(p_phi2 == 1'b0, "R4 rise aligned", p_phi2, 0);
    end
  end

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int highs, falls;
    logic prev;
    rst_n = 1'b0; h_addr = '0; h_data = '0; h_rw = 1'b1; h_iosel = 1'b0;
    #30;
    // R9
    chk(p_cs_n == 1'b1, "R9 cs_n in reset", p_cs_n, 1);
    chk(h_busy == 1'b0, "R9 busy in reset", h_busy, 0);
    chk(h_overrun == 1'b0, "R9 overrun in reset", h_overrun, 0);
    chk(p_rw == 1'b0, "R6 rw in reset", p_rw, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge h_phi2);

    // R7: 4*DIV samples hold 2*DIV highs and 4 falls
    @(posedge ref_clk); #1 prev = p_phi2;
    highs = 0; falls = 0;
    for (int i = 0; i < 4 * DIV; i++) begin
      @(posedge ref_clk); #1;
      if (p_phi2) highs++;
      if (prev && !p_phi2) falls++;
      prev = p_phi2;
    end
    chk(highs == 2 * DIV, "R7 high time", highs, 2 * DIV);
    chk(falls == 4, "R7 period", falls, 4);

    // R1 R2 R10: accepted writes across the window
    bus_cycle(BASE,       8'h11, 1'b0, 1'b1, 1'b1); wait_idle();
    bus_cycle(BASE + 31,  8'hE7, 1'b0, 1'b1, 1'b1); wait_idle();
    bus_cycle(BASE + 5,   8'h5A, 1'b0, 1'b1, 1'b1); wait_idle();
    bus_cycle(BASE + 18,  8'h00, 1'b0, 1'b1, 1'b1); wait_idle();
    bus_cycle(BASE + 10,  8'hFF, 1'b0, 1'b1, 1'b1); wait_idle();

    // R3 R10: ignored cycles
    bus_cycle(BASE + 3,   8'h33, 1'b1, 1'b1, 1'b0);
    chk(h_busy == 1'b0, "R3 read ignored", h_busy, 0);
    bus_cycle(BASE + 4,   8'h44, 1'b0, 1'b0, 1'b0);
    chk(h_busy == 1'b0, "R3 no decode ignored", h_busy, 0);
    bus_cycle(BASE + 32,  8'h55, 1'b0, 1'b1, 1'b0);
    chk(h_busy == 1'b0, "R10 above window", h_busy, 0);
    bus_cycle(BASE - 1,   8'h66, 1'b0, 1'b1, 1'b0);
    chk(h_busy == 1'b0, "R10 below window", h_busy, 0);
    #300;
    chk(exp_q.size() == 0, "R3 R10 no pulse", exp_q.size(), 0);

    // R8: back-to-back stores
    chk(h_overrun == 1'b0, "R8 overrun clear", h_overrun, 0);
    bus_cycle(BASE + 7, 8'h3C, 1'b0, 1'b1, 1'b1);
    bus_cycle(BASE + 8, 8'hC3, 1'b0, 1'b1, 1'b0);
    chk(h_overrun == 1'b1, "R8 overrun set", h_overrun, 1);
    wait_idle();
    bus_cycle(BASE + 9, 8'h96, 1'b0, 1'b1, 1'b1);
    chk(h_overrun == 1'b1, "R8 overrun sticky", h_overrun, 1);
    wait_idle();

    #500;
    chk(exp_q.size() == 0, "R1 every pulse seen", exp_q.size(), 0);

    // R9: reset clears status
    rst_n = 1'b0;
    #20;
    chk(h_overrun == 1'b0, "R9 overrun reset", h_overrun, 0);
    chk(h_busy == 1'b0, "R9 busy reset", h_busy, 0);
    chk(p_cs_n == 1'b1, "R9 cs_n reset", p_cs_n, 1);
    rst_n = 1'b1;
    #100;
    summary();
  end
endmodule